// File: doc/BRIEF.md
# Randomized Dummy Instruction Scheduler

This block decides when a processor pipeline should slip in an extra instruction that does no work, and which instruction it should be. The point is to blur the timing and power profile of the real code. It holds three 32-bit linear feedback shift registers (LFSRs), and all three step once per clock:

- The first LFSR sets how many real instructions pass between two dummies. It also picks the operation kind: add, multiply or unsigned branch-less-than.
- The second and third LFSRs supply the two operand values. Operands never come from the register file.

A 4-bit frequency code sets the window the random gap is drawn from. The pipeline reports each issued real instruction with a one-cycle strobe. The scheduler answers with a one-cycle insert pulse, which carries the operation select, both operands and a flag telling the retire counter to ignore the inserted instruction.

The same generator serves a second case: a hint instruction that software placed in the stream can be swapped for a random instruction. When that replacement is enabled, the hint is turned into a random instruction that still counts as retired. When it is disabled, the hint stays a plain nop and nothing is inserted.

Software may overwrite any LFSR state at any time. If an LFSR ever holds all zeros, it cannot move on by itself. In that case it reloads its default seed on the next clock, and a minor alert is high for the cycle in which the zero state is present.

Top module: `rnd_filler_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, `ins_valid_o` and `no_retire_o` are 0, `lockup_alert_o` is 0, and each LFSR holds its default seed. So a hint replacement strobed in the first cycle after reset returns operands equal to the second and third default seeds.
- R2: Every clock, each LFSR state S advances to `(S << 1) ^ (S[31] ? COEFF : 0)`, using the coefficient word of that LFSR. This applies unless a seed write or a lockup reload takes precedence.
- R3: The interval counter is reloaded with `(LFSR0[5:0] & {freq_i, 2'b11}) + 1`. Codes 0000, 0001, 0011, 0111 and 1111 therefore give windows of 1–4, 1–8, 1–16, 1–32 and 1–64 real instructions. Any other code is legal and is used as the same mask.
- R4: The counter drops by one on every cycle where `en_i`, `instr_i` and no hint replacement coincide. On the strobe that finds the counter at 1, the counter reloads, and on the next cycle `ins_valid_o` = 1 and `no_retire_o` = 1 for exactly one cycle.
- R5: On an insert, `ins_op_o` takes LFSR0[1:0] as it stood at the triggering edge. The encoding is add = 0, multiply = 1, unsigned branch-less-than = 2, and the raw value 3 is mapped to add. The output never shows 3.
- R6: On an insert, `opa_o` and `opb_o` take the LFSR1 and LFSR2 states from the triggering edge. Between inserts, the operation and operand outputs hold their values.
- R7: When `hint_i` and `hint_en_i` are both high, the next cycle shows `ins_valid_o` = 1 with `no_retire_o` = 0. The interval counter does not move in that cycle, even if `instr_i` is high.
- R8: A hint with `hint_en_i` = 0 produces no insert. With `en_i` = 0, no dummy is requested and the interval counter holds.
- R9: Bit i of `seed_wr_i` loads `seed_data_i` into LFSR i at the clock edge. The write overrides the step and the lockup reload.
- R10: While an LFSR state is all zeros, `lockup_alert_o` is 1. At the next edge that LFSR reloads its default seed, and the alert falls unless another zero is written.
- R11: After reset, the first real instruction with `en_i` = 1 triggers a dummy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Dummy insertion enable |
| freq_i | input | 4 | Window code, used as a mask on the random count |
| instr_i | input | 1 | Strobe, one real instruction issued |
| hint_i | input | 1 | Strobe, hint instruction seen |
| hint_en_i | input | 1 | Replace hints with random instructions |
| seed_wr_i | input | 3 | Per-LFSR seed write strobes |
| seed_data_i | input | 32 | Seed value for a write |
| ins_valid_o | output | 1 | Insert a random instruction this cycle |
| ins_op_o | output | 2 | Operation: 0 add, 1 multiply, 2 unsigned branch-less-than |
| opa_o | output | 32 | First operand |
| opb_o | output | 32 | Second operand |
| no_retire_o | output | 1 | Inserted instruction must not count as retired |
| lockup_alert_o | output | 1 | Minor alert, an LFSR is all zeros |

## Verification
The bench goes after the smallest window, checking that no gap ever exceeds four real instructions. A counter that reloaded without the +1, or that used the wrong mask bits, would let gaps run long or collapse to zero.

It writes a zero seed and checks that the alert lasts exactly one cycle and that the default seed comes back. A design that stepped the zero state instead would stay locked up with the alert held high.

It strobes a replaced hint together with a real instruction. A design that let the counter move on that cycle would fire the next dummy one instruction early, or would mark the hint as not retired.

It checks the first instruction after reset and operation code 3. A wrong reset count or a missing remap would show up as a late first dummy or as an illegal operation select.

// File: rtl/rnd_filler_sched.sv
module rnd_filler_sched #(
  parameter int W = 32,
  parameter int CNT_W = 7,
  parameter logic [W-1:0] COEFF0 = 32'h04C1_1DB7,
  parameter logic [W-1:0] COEFF1 = 32'h1EDC_6F41,
  parameter logic [W-1:0] COEFF2 = 32'h741B_8CD7,
  parameter logic [W-1:0] SEED0  = 32'hACE1_2345,
  parameter logic [W-1:0] SEED1  = 32'h1357_9BDF,
  parameter logic [W-1:0] SEED2  = 32'hC0FF_EE11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [3:0]   freq_i,
  input  logic         instr_i,
  input  logic         hint_i,
  input  logic         hint_en_i,
  input  logic [2:0]   seed_wr_i,
  input  logic [W-1:0] seed_data_i,
  output logic         ins_valid_o,
  output logic [1:0]   ins_op_o,
  output logic [W-1:0] opa_o,
  output logic [W-1:0] opb_o,
  output logic         no_retire_o,
  output logic         lockup_alert_o
);
  localparam int NL = 3;
  localparam int MW = 6;
  localparam logic [NL-1:0][W-1:0] CO = {COEFF2, COEFF1, COEFF0};
  localparam logic [NL-1:0][W-1:0] SD = {SEED2, SEED1, SEED0};

  logic [NL-1:0][W-1:0] st;
  logic [NL-1:0]        zero;
  logic [CNT_W-1:0]     cnt;
  logic [MW-1:0]        mask;
  logic                 hint_fire, count_en, dum_fire, any_fire;

  assign mask      = {freq_i, 2'b11};
  assign hint_fire = hint_i & hint_en_i;
  assign count_en  = en_i & instr_i & ~hint_fire;
  assign dum_fire  = count_en & (cnt == CNT_W'(1));
  assign any_fire  = dum_fire | hint_fire;
  assign lockup_alert_o = |zero;

  for (genvar g = 0; g < NL; g++) begin : g_lfsr
    assign zero[g] = (st[g] == '0);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            st[g] <= SD[g];
      else if (seed_wr_i[g])  st[g] <= seed_data_i;
      else if (zero[g])       st[g] <= SD[g];
      else                    st[g] <= {st[g][W-2:0], 1'b0} ^ (st[g][W-1] ? CO[g] : '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt <= CNT_W'(1);
    else if (count_en) begin
      if (cnt == CNT_W'(1)) cnt <= CNT_W'(st[0][MW-1:0] & mask) + CNT_W'(1);
      else                  cnt <= cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ins_valid_o <= 1'b0;
      no_retire_o <= 1'b0;
      ins_op_o    <= 2'd0;
      opa_o       <= '0;
      opb_o       <= '0;
    end else begin
      ins_valid_o <= any_fire;
      no_retire_o <= dum_fire;
      if (any_fire) begin
        ins_op_o <= (st[0][1:0] == 2'd3) ? 2'd0 : st[0][1:0];
        opa_o    <= st[1];
        opb_o    <= st[2];
      end
    end
  end
endmodule

module rnd_filler_sched_chk #(parameter int W = 32) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en_i,
  input logic         hint_i,
  input logic         hint_en_i,
  input logic [2:0]   seed_wr_i,
  input logic         ins_valid_o,
  input logic [1:0]   ins_op_o,
  input logic [W-1:0] opa_o,
  input logic [W-1:0] opb_o,
  input logic         no_retire_o,
  input logic         lockup_alert_o
);
  // R5
  op_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_op_o != 2'd3);
  // R7
  hint_replace_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hint_i && hint_en_i) |=> (ins_valid_o && !no_retire_o));
  // R8
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !(hint_i && hint_en_i)) |=> !ins_valid_o);
  // R4
  retire_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_retire_o |-> ins_valid_o);
  // R6
  operand_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ins_valid_o |-> ($stable(opa_o) && $stable(opb_o) && $stable(ins_op_o)));
  // R10
  alert_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lockup_alert_o && seed_wr_i == 3'b000) |=> !lockup_alert_o);
endmodule

bind rnd_filler_sched rnd_filler_sched_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .hint_i(hint_i),
  .hint_en_i(hint_en_i), .seed_wr_i(seed_wr_i), .ins_valid_o(ins_valid_o),
  .ins_op_o(ins_op_o), .opa_o(opa_o), .opb_o(opb_o),
  .no_retire_o(no_retire_o), .lockup_alert_o(lockup_alert_o)
);

// File: tb/rnd_filler_sched_tb.sv
module rnd_filler_sched_tb;
  localparam int CLK_P = 10;
  localparam logic [31:0] C0 = 32'h04C1_1DB7, C1 = 32'h1EDC_6F41, C2 = 32'h741B_8CD7;
  localparam logic [31:0] S0 = 32'hACE1_2345, S1 = 32'h1357_9BDF, S2 = 32'hC0FF_EE11;
  // {en, freq[3:0], instr, hint, hint_en}
  localparam int NV = 12;
  localparam logic [7:0] VEC [NV] = '{
    8'b1_0000_1_0_0, 8'b1_0001_1_0_0, 8'b1_0011_1_0_0, 8'b1_0111_1_0_0,
    8'b1_1111_1_0_0, 8'b1_0101_1_0_0, 8'b1_0000_1_1_1, 8'b0_0000_1_1_1,
    8'b0_0011_1_1_0, 8'b1_1010_1_1_0, 8'b1_0001_0_1_1, 8'b1_0000_1_1_0};

  logic clk = 0, rst_n = 0;
  logic en = 0, instr = 0, hint = 0, hint_en = 0;
  logic [3:0] freq = 0;
  logic [2:0] seed_wr = 0;
  logic [31:0] seed_data = 0;
  logic v, nr, alert;
  logic [1:0] op;
  logic [31:0] a, b;
  int checks = 0, failures = 0;
  bit done = 0;

  logic [31:0] m_st [3];
  int m_cnt;
  logic m_v, m_nr;
  logic [1:0] m_op;
  logic [31:0] m_a, m_b;

  always #(CLK_P/2) clk = ~clk;

  rnd_filler_sched u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .freq_i(freq), .instr_i(instr),
    .hint_i(hint), .hint_en_i(hint_en), .seed_wr_i(seed_wr), .seed_data_i(seed_data),
    .ins_valid_o(v), .ins_op_o(op), .opa_o(a), .opb_o(b),
    .no_retire_o(nr), .lockup_alert_o(alert));

  function automatic logic [31:0] adv(logic [31:0] s, logic [31:0] c);
    return {s[30:0], 1'b0} ^ (s[31] ? c : 32'h0);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_st[0] = S0; m_st[1] = S1; m_st[2] = S2;
    m_cnt = 1; m_v = 0; m_nr = 0; m_op = 0; m_a = 0; m_b = 0;
  endtask

  task automatic model_edge();
    bit hf, ce, df;
    logic [31:0] c [3];
    logic [31:0] d [3];
    c[0] = C0; c[1] = C1; c[2] = C2; d[0] = S0; d[1] = S1; d[2] = S2;
    hf = hint && hint_en;
    ce = en && instr && !hf;
    df = ce && (m_cnt == 1);
    m_v = df || hf;
    m_nr = df;
    if (df || hf) begin
      m_op = (m_st[0][1:0] == 2'd3) ? 2'd0 : m_st[0][1:0];
      m_a = m_st[1]; m_b = m_st[2];
    end
    if (ce) m_cnt = (m_cnt == 1) ? int'(m_st[0][5:0] & {freq, 2'b11}) + 1 : m_cnt - 1;
    for (int i = 0; i < 3; i++) begin
      if (seed_wr[i]) m_st[i] = seed_data;
      else if (m_st[i] == 0) m_st[i] = d[i];
      else m_st[i] = adv(m_st[i], c[i]);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1 model_edge();
    @(negedge clk);
    chk(v == m_v, "R4/R7/R8 valid", 32'(v), 32'(m_v));
    chk(nr == m_nr, "R4/R7 no_retire", 32'(nr), 32'(m_nr));
    chk(op == m_op, "R5 op", 32'(op), 32'(m_op));
    chk(a == m_a, "R2/R6 opa", a, m_a);
    chk(b == m_b, "R2/R6 opb", b, m_b);
    chk(alert == ((m_st[0] == 0) || (m_st[1] == 0) || (m_st[2] == 0)), "R10 alert", 32'(alert), 32'h0);
  endtask

  task automatic do_reset();
    rst_n = 0; en = 0; instr = 0; hint = 0; hint_en = 0; seed_wr = 0;
    repeat (2) @(negedge clk);
    model_reset();
    chk(v == 0 && nr == 0 && alert == 0, "R1 reset outputs", {v, nr, alert}, 32'h0);
    rst_n = 1;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int gap, maxgap, lastgap;
    @(negedge clk);
    do_reset();
    // R1: first-cycle hint returns default seeds
    hint = 1; hint_en = 1;
    tick();
    hint = 0;
    chk(a == S1, "R1 seed1", a, S1);
    chk(b == S2, "R1 seed2", b, S2);
    chk(!nr && v, "R7 hint retires", {v, nr}, 32'h2);
    // R11: first instruction after reset triggers a dummy
    do_reset();
    en = 1; freq = 4'b0000; instr = 1;
    tick();
    instr = 0;
    chk(v && nr, "R11 first dummy", {v, nr}, 32'h3);
    tick();
    // vector table walk
    for (int k = 0; k < NV; k++) begin
      {en, freq} = VEC[k][7:3];
      hint_en = VEC[k][0];
      for (int j = 0; j < 40; j++) begin
        instr = VEC[k][2] && (j % 5 != 4);
        hint = VEC[k][1] && (j % 3 == 0);
        tick();
      end
    end
    instr = 0; hint = 0; hint_en = 0;
    // R3: smallest window, gap never exceeds 4
    en = 1; freq = 4'b0000; instr = 1; gap = 0; maxgap = 0;
    for (int j = 0; j < 400; j++) begin
      tick();
      gap++;
      if (v) begin
        if (gap > maxgap) maxgap = gap;
        gap = 0;
      end
    end
    chk(maxgap <= 4 && maxgap >= 2, "R3 window 1-4", maxgap, 4);
    // R3: widest window reaches gaps beyond 4 and stays within 64
    freq = 4'b1111; gap = 0; maxgap = 0;
    for (int j = 0; j < 3000; j++) begin
      tick();
      gap++;
      if (v) begin
        if (gap > maxgap) maxgap = gap;
        gap = 0;
      end
    end
    chk(maxgap <= 65 && maxgap > 8, "R3 window 1-64", maxgap, 64);
    // R7: replaced hint freezes the counter
    freq = 4'b0000;
    while (!v) tick();
    hint = 1; hint_en = 1; lastgap = 0;
    repeat (3) tick();
    hint = 0;
    for (int j = 0; j < 6; j++) begin
      tick();
      if (!v) lastgap++; else break;
    end
    chk(lastgap <= 4, "R7 counter held", lastgap, 4);
    instr = 0; hint_en = 0;
    // R8: disabled hint produces nothing
    hint = 1; en = 0;
    tick(); tick();
    chk(!v, "R8 hint nop", 32'(v), 32'h0);
    hint = 0;
    // R9/R10: zero seed write locks up LFSR1 for one cycle
    seed_wr = 3'b010; seed_data = 32'h0;
    tick();
    seed_wr = 0;
    chk(alert == 1, "R10 alert high", 32'(alert), 32'h1);
    hint = 1; hint_en = 1;
    tick();
    chk(alert == 0, "R10 alert low", 32'(alert), 32'h0);
    chk(a == 32'h0, "R10 zero state seen", a, 32'h0);
    tick();
    chk(a == S1, "R10 reseed default", a, S1);
    // R9: arbitrary seed write
    seed_wr = 3'b100; seed_data = 32'h1234_5678;
    tick();
    seed_wr = 0;
    tick();
    chk(b == 32'h1234_5678, "R9 seed write", b, 32'h1234_5678);
    // R5: force LFSR0 low bits to 3, expect add
    seed_wr = 3'b001; seed_data = 32'h0000_0003;
    hint = 0;
    tick();
    seed_wr = 0; hint = 1;
    tick();
    chk(op == 2'd0, "R5 code3 to add", 32'(op), 32'h0);
    hint = 0;
    tick();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule